// File: doc/BRIEF.md
# Two-Cycle Address/Command Launcher

This block sits between the command scheduler of a DDR2 memory controller and the address/command pins of a bus with many loads, such as a pair of unbuffered modules. On such a bus the address and command lines can see dozens of receivers. Their edges may then take longer than one clock to settle. The block gives those lines two full clock periods to settle. It launches address, bank and the RAS/CAS/WE command one clock ahead of the sampling cycle and holds them for two clocks. Only the chip-select of the addressed rank goes low, and only in the second cycle. Chip-select loads just one rank, so its edges stay fast, and it tells the memory exactly when to latch. No extra latency cycle is added, as a registered module would add. The cost is that at most one command reaches the memory every two clocks.

The scheduler offers commands through a valid/ready handshake. A mode input selects either two-cycle timing or plain single-cycle timing. In single-cycle timing, chip-select goes low in the same cycle as the command, and a new command may be issued every clock. Every pin output comes straight from a flip-flop.

Top module: `ddr_two_cycle_launcher`

## Requirements
- R1: While reset is held, the outputs are in their idle state: all chip-selects high, RAS/CAS/WE all high (no-operation), address and bank zero, and `cmd_ready` high.
- R2: In two-cycle mode, a command accepted at a clock edge (`cmd_valid` and `cmd_ready` both high) appears on address, bank and RAS/CAS/WE in the following cycle, with every chip-select high. `cmd_op` bit 2 drives RAS#, bit 1 drives CAS#, and bit 0 drives WE#.
- R3: In two-cycle mode, the address, bank and command from R2 stay unchanged for a second cycle. In that second cycle the chip-select of the addressed rank is low.
- R4: In two-cycle mode, `cmd_ready` is low for the cycle after an accepted command. A `cmd_valid` offered in that cycle is not accepted and does not change the pins. `cmd_ready` returns high in the cycle after that.
- R5: In single-cycle mode (`two_cyc_en` low), an accepted command appears in the next cycle together with a low chip-select for its rank. `cmd_ready` stays high, so commands can issue on consecutive clocks.
- R6: In a cycle that neither launches nor completes a command, RAS/CAS/WE are all high and every chip-select is high. Address and bank keep their last values.
- R7: At most one chip-select is low in any cycle. The low one is `mem_cs_n[cmd_rank]` of the command it belongs to.
- R8: The mode is sampled when a command is accepted. A two-cycle slot that has started completes with its chip-select in the second cycle, even if `two_cyc_en` falls in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_cyc_en | input | 1 | 1 selects two-cycle timing, 0 selects single-cycle timing |
| cmd_valid | input | 1 | Scheduler offers a command |
| cmd_ready | output | 1 | Launcher can take a command this cycle |
| cmd_addr | input | ADDR_W (14) | Row/column address of the command |
| cmd_bank | input | BANK_W (3) | Bank address of the command |
| cmd_rank | input | RANK_W (1) | Rank whose chip-select qualifies the command |
| cmd_op | input | 3 | {RAS#, CAS#, WE#} levels of the command |
| mem_addr | output | ADDR_W (14) | Registered address pins |
| mem_ba | output | BANK_W (3) | Registered bank pins |
| mem_ras_n | output | 1 | Registered RAS# pin |
| mem_cas_n | output | 1 | Registered CAS# pin |
| mem_we_n | output | 1 | Registered WE# pin |
| mem_cs_n | output | NUM_RANKS (2) | Registered active-low chip-select per rank |

## Verification
The bench aims at the second cycle of a two-cycle slot. A design that dropped the hold would show a no-operation or a stale chip-select there. A design that fired chip-select in the launch cycle would let the memory sample address lines that are still moving. It offers a valid command while ready is low. A design that dropped or took that command would change the pins in the middle of a slot. It drops the mode enable between launch and strobe. A design that read the enable late would lose the strobe of a command already on the bus. It also runs back-to-back single-cycle commands and rank changes, which expose a chip-select that follows the wrong rank or a ready that stalls when it should not.

// File: rtl/acl_pkg.sv
package acl_pkg;

    typedef enum logic {
        SLOT_OPEN = 1'b0,
        SLOT_HOLD = 1'b1
    } slot_e;

    localparam logic [2:0] CMD_NOP = 3'b111;

endpackage

// File: rtl/acl_slot_ctrl.sv
module acl_slot_ctrl
    import acl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  two_cyc_en,
    input  logic  cmd_valid,
    output logic  cmd_ready,
    output logic  take,
    output logic  cs_fire,
    output logic  go_idle,
    output slot_e slot_q_o
);

    typedef struct packed {
        slot_e slot;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d    = ctrl_q;
        cmd_ready = (ctrl_q.slot == SLOT_OPEN);
        take      = cmd_valid & cmd_ready;
        cs_fire   = (take & ~two_cyc_en) | (ctrl_q.slot == SLOT_HOLD);
        go_idle   = ~take & (ctrl_q.slot == SLOT_OPEN);
        if (take && two_cyc_en) begin
            ctrl_d.slot = SLOT_HOLD;
        end else begin
            ctrl_d.slot = SLOT_OPEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{slot: SLOT_OPEN};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign slot_q_o = ctrl_q.slot;

    AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && two_cyc_en) |=> !cmd_ready); // R4
    AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> cmd_ready); // R4
    AST_SINGLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !two_cyc_en) |=> cmd_ready); // R5

endmodule

// File: rtl/acl_pin_reg.sv
module acl_pin_reg
    import acl_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              go_idle,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [2:0]        in_op,
    output logic [ADDR_W-1:0] pin_addr,
    output logic [BANK_W-1:0] pin_ba,
    output logic [2:0]        pin_op
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] ba;
        logic [2:0]        op;
    } pins_t;

    pins_t pins_d, pins_q;

    always_comb begin
        pins_d = pins_q;
        if (load) begin
            pins_d.addr = in_addr;
            pins_d.ba   = in_bank;
            pins_d.op   = in_op;
        end else if (go_idle) begin
            pins_d.op   = CMD_NOP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '{addr: '0, ba: '0, op: CMD_NOP};
        end else begin
            pins_q <= pins_d;
        end
    end

    assign pin_addr = pins_q.addr;
    assign pin_ba   = pins_q.ba;
    assign pin_op   = pins_q.op;

    AST_IDLE_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> $stable(pin_addr) && $stable(pin_ba)); // R6

endmodule

// File: rtl/acl_cs_gen.sv
module acl_cs_gen #(
    parameter int NUM_RANKS = 2,
    parameter int RANK_W    = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 cs_fire,
    input  logic [RANK_W-1:0]    in_rank,
    output logic [NUM_RANKS-1:0] cs_n
);

    typedef struct packed {
        logic [RANK_W-1:0]    rank;
        logic [NUM_RANKS-1:0] cs_n;
    } csst_t;

    csst_t cs_d, cs_q;
    logic [RANK_W-1:0]    sel_rank;
    logic [NUM_RANKS-1:0] hit;

    assign sel_rank = load ? in_rank : cs_q.rank;

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        assign hit[r] = (sel_rank == RANK_W'(r));
    end

    always_comb begin
        cs_d = cs_q;
        if (load) begin
            cs_d.rank = in_rank;
        end
        cs_d.cs_n = ~(hit & {NUM_RANKS{cs_fire}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '{rank: '0, cs_n: '1};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign cs_n = cs_q.cs_n;

    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R7

endmodule

// File: rtl/ddr_two_cycle_launcher.sv
module ddr_two_cycle_launcher
    import acl_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int BANK_W    = 3,
    parameter int NUM_RANKS = 2,
    localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 two_cyc_en,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic [RANK_W-1:0]    cmd_rank,
    input  logic [2:0]           cmd_op,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BANK_W-1:0]    mem_ba,
    output logic                 mem_ras_n,
    output logic                 mem_cas_n,
    output logic                 mem_we_n,
    output logic [NUM_RANKS-1:0] mem_cs_n
);

    logic  take;
    logic  cs_fire;
    logic  go_idle;
    slot_e slot_q;
    logic [2:0] pin_op;

    acl_slot_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .two_cyc_en (two_cyc_en),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .take       (take),
        .cs_fire    (cs_fire),
        .go_idle    (go_idle),
        .slot_q_o   (slot_q)
    );

    acl_pin_reg #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .go_idle  (go_idle),
        .in_addr  (cmd_addr),
        .in_bank  (cmd_bank),
        .in_op    (cmd_op),
        .pin_addr (mem_addr),
        .pin_ba   (mem_ba),
        .pin_op   (pin_op)
    );

    acl_cs_gen #(
        .NUM_RANKS (NUM_RANKS),
        .RANK_W    (RANK_W)
    ) u_cs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take),
        .cs_fire (cs_fire),
        .in_rank (cmd_rank),
        .cs_n    (mem_cs_n)
    );

    assign mem_ras_n = pin_op[2];
    assign mem_cas_n = pin_op[1];
    assign mem_we_n  = pin_op[0];

    AST_LAUNCH_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_HOLD) |-> (&mem_cs_n)); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_HOLD) |=> $stable(mem_addr) && $stable(mem_ba)
            && $stable(pin_op) && !(&mem_cs_n)); // R3
    AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_q == SLOT_OPEN) && (&mem_cs_n)) |-> (pin_op == CMD_NOP)); // R6
    AST_SLOT_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_HOLD && !two_cyc_en) |=> !(&mem_cs_n)); // R8

endmodule

// File: tb/ddr_two_cycle_launcher_tb.sv
`timescale 1ns/1ps
module ddr_two_cycle_launcher_tb;

    localparam int AW = 14;
    localparam int BW = 3;
    localparam int NR = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          two_cyc_en = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [BW-1:0] cmd_bank = '0;
    logic          cmd_rank = 1'b0;
    logic [2:0]    cmd_op = 3'b111;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_ba;
    logic          mem_ras_n, mem_cas_n, mem_we_n;
    logic [NR-1:0] mem_cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ddr_two_cycle_launcher u_dut (
        .clk (clk), .rst_n (rst_n), .two_cyc_en (two_cyc_en),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
        .cmd_addr (cmd_addr), .cmd_bank (cmd_bank), .cmd_rank (cmd_rank),
        .cmd_op (cmd_op), .mem_addr (mem_addr), .mem_ba (mem_ba),
        .mem_ras_n (mem_ras_n), .mem_cas_n (mem_cas_n), .mem_we_n (mem_we_n),
        .mem_cs_n (mem_cs_n)
    );

    // Expected pin state, built from the requirements
    bit            m_hold;
    logic [AW-1:0] m_addr;
    logic [BW-1:0] m_ba;
    logic [2:0]    m_op;
    logic          m_rank;
    logic [NR-1:0] m_cs;
    string         m_tag;

    function automatic logic [NR-1:0] cs_for(input logic rank);
        logic [NR-1:0] v = '1;
        v[rank] = 1'b0;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold <= 1'b0; m_addr <= '0; m_ba <= '0; m_op <= 3'b111;
            m_rank <= 1'b0; m_cs <= '1; m_tag <= "R1";
        end else if (cmd_valid && !m_hold) begin
            m_addr <= cmd_addr; m_ba <= cmd_bank; m_op <= cmd_op; m_rank <= cmd_rank;
            if (two_cyc_en) begin
                m_hold <= 1'b1; m_cs <= '1; m_tag <= "R2";
            end else begin
                m_hold <= 1'b0; m_cs <= cs_for(cmd_rank); m_tag <= "R5";
            end
        end else if (m_hold) begin
            m_hold <= 1'b0; m_cs <= cs_for(m_rank); m_tag <= "R3";
        end else begin
            m_op <= 3'b111; m_cs <= '1; m_tag <= "R6";
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_pins();
        chk(m_tag, "addr", 32'(mem_addr), 32'(m_addr));
        chk(m_tag, "bank", 32'(mem_ba), 32'(m_ba));
        chk(m_tag, "ras/cas/we", 32'({mem_ras_n, mem_cas_n, mem_we_n}), 32'(m_op));
        chk(m_tag, "cs_n", 32'(mem_cs_n), 32'(m_cs));
        chk("R4", "cmd_ready", 32'(cmd_ready), 32'(!m_hold));
        chk("R7", "cs low count <= 1", 32'($countones(~mem_cs_n) <= 1), 32'd1);
    endtask

    task automatic rand_cmd();
        cmd_addr = AW'($urandom);
        cmd_bank = BW'($urandom);
        cmd_rank = 1'($urandom);
        cmd_op   = 3'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5eed_2c1a));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "cs_n", 32'(mem_cs_n), 32'h3);
        chk("R1", "ras/cas/we", 32'({mem_ras_n, mem_cas_n, mem_we_n}), 32'h7);
        chk("R1", "addr", 32'(mem_addr), 32'h0);
        chk("R1", "ready", 32'(cmd_ready), 32'h1);
        rst_n = 1'b1;

        // Directed: mode drops mid-slot (R8), valid offered while busy (R4)
        two_cyc_en = 1'b1; cmd_valid = 1'b1;
        cmd_addr = 14'h2a5a; cmd_bank = 3'd5; cmd_rank = 1'b1; cmd_op = 3'b011;
        @(negedge clk);
        check_pins();
        chk("R2", "launch cs_n high", 32'(mem_cs_n), 32'h3);
        chk("R2", "launch addr", 32'(mem_addr), 32'h2a5a);
        two_cyc_en = 1'b0; cmd_valid = 1'b1;
        cmd_addr = 14'h0111; cmd_rank = 1'b0; cmd_op = 3'b101;
        @(negedge clk);
        check_pins();
        chk("R8", "strobe after enable drop", 32'(mem_cs_n), 32'h1);
        chk("R4", "busy offer ignored addr", 32'(mem_addr), 32'h2a5a);
        cmd_valid = 1'b0;
        @(negedge clk);
        check_pins();

        // Directed: back-to-back single-cycle commands on alternating ranks
        for (int i = 0; i < 4; i++) begin
            cmd_valid = 1'b1; rand_cmd(); cmd_rank = 1'(i);
            @(negedge clk);
            check_pins();
            chk("R5", "single strobe rank", 32'(mem_cs_n), 32'(cs_for(1'(i))));
        end
        cmd_valid = 1'b0;
        @(negedge clk);
        check_pins();

        // Constrained random: mode changes in bursts, occasional toggles
        for (int c = 0; c < 4000; c++) begin
            if (c % 200 == 0) two_cyc_en = 1'($urandom);
            else if ($urandom_range(0, 19) == 0) two_cyc_en = ~two_cyc_en;
            cmd_valid = ($urandom_range(0, 3) != 0);
            rand_cmd();
            @(negedge clk);
            check_pins();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule